// File: doc/BRIEF.md
# Programmable Interval Timer with Compare Match

This block is a bus-programmed interval timer. A prescaler divides the system clock, and each prescaled tick advances an up-counter whose width is a parameter. When the counter holds the value in the compare register at a tick, a match event sets a sticky status flag. Software sees that flag on an interrupt line when it has enabled the interrupt. The counter can either reload to zero on a match, which gives a periodic tick source, or run on through the match to its natural wrap, which gives a free-running time base that still reports the compare point.

Software drives the block through a small register port. Writes are single-cycle strobes and reads are combinational from the register state. The control register starts and stops counting and selects whether the prescaler divides at all. It also carries a counter-reset option that zeroes the count when the timer stops, but only after the timer has run once with that option set. The counter itself can be read at any time.

Top module: `interval_timer`

## Requirements
- R1: After reset, control (0x00), status (0x04), interval mode (0x10), clock divide (0x20) and counter (0xF0) read zero, compare (0x08) reads all ones in the low CNT_W bits, and irq is low.
- R2: While the run bit (control bit 0) is set, the counter advances once per prescale period. With the divide-enable bit (control bit 2) clear, the period is one clock. With it set, the period is 2<<ccd clocks, where ccd is clock divide bits [2:0]. The first advance comes a full period after the start, and the counter holds its value while run is clear.
- R3: A tick that finds the counter equal to compare is a match, and it sets status bit 0.
- R4: With zero-clear enable (interval mode bit 0) set, the counter goes to 0 on a match instead of advancing.
- R5: With zero-clear enable clear, the counter advances past the compare value and wraps from all ones to 0.
- R6: irq is high exactly while status bit 0 and interrupt enable (interval mode bit 1) are both set.
- R7: A write to status with bit 0 equal to 0 clears the flag, and writing 1 has no effect. A match in the same cycle as a clearing write leaves the flag set.
- R8: When a control write clears run while the counter-reset bit (control bit 1) is set in the new value, the counter becomes 0, provided the timer has spent at least one cycle running with that bit set since it was last written 0. Otherwise stopping freezes the count.
- R9: The counter register at 0xF0 returns the live count zero-extended to 32 bits. Reading it does not disturb counting, and writes to it are ignored.
- R10: Only interval mode exists: control bits [5:4] always read 0, whatever is written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for bus_en |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Compare-match interrupt request |

## Verification
The assertions assume that every register write lands as a single-cycle strobe with a stable address, and that the compare and divide values do not change in the cycle a tick uses them. The stimulus meets this by driving one access per clock on the falling edge and by changing compare or divide only while the timer is stopped. Stops are placed on cycles where the counter is away from the compare value, so each zeroing the bench sees comes from one cause only. The single exception is the deliberate collision between a status clear and a match.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam logic [7:0] ADDR_CTRL  = 8'h00;
    localparam logic [7:0] ADDR_STAT  = 8'h04;
    localparam logic [7:0] ADDR_CMP   = 8'h08;
    localparam logic [7:0] ADDR_IMODE = 8'h10;
    localparam logic [7:0] ADDR_DIV   = 8'h20;
    localparam logic [7:0] ADDR_CNT   = 8'hF0;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_CRST_BIT = 1;
    localparam int CTRL_DIVE_BIT = 2;

    localparam int IMODE_ZCLR_BIT = 0;
    localparam int IMODE_IEN_BIT  = 1;

    localparam logic [1:0] MODE_INTERVAL = 2'b00;
endpackage

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             div_en_i,
    input  logic [DIV_W-1:0] ccd_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << DIV_W) + 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last   = (PRE_W'(2) << ccd_i) - PRE_W'(1);
        pre_d  = pre_q;
        tick_o = 1'b0;
        if (!run_i) begin
            pre_d = '0;
        end else if (!div_en_i) begin
            pre_d  = '0;
            tick_o = 1'b1;
        end else if (pre_q == last) begin
            pre_d  = '0;
            tick_o = 1'b1;
        end else begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: a divided period is at least two clocks long
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_en_i) |=> !(tick_o && div_en_i));
endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             zclr_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        match_o = tick_i && (cnt_q == cmp_i);
        cnt_d   = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (match_o && zclr_i) cnt_d = '0;
            else                   cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R5: the full-width count rolls over to zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !match_o && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 24,
    parameter int DIV_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import timer_pkg::*;

    typedef struct packed {
        logic             run;
        logic             crst;
        logic             div_en;
        logic             armed;
        logic             zclr;
        logic             ien;
        logic             flag;
        logic [DIV_W-1:0] ccd;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;

    logic             wr;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             stop_clr;
    logic             tick;
    logic             match;
    logic [CNT_W-1:0] cnt;

    itmr_prescale #(.DIV_W(DIV_W)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (r_q.run),
        .div_en_i (r_q.div_en),
        .ccd_i    (r_q.ccd),
        .tick_o   (tick)
    );

    itmr_count #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clr_i   (stop_clr),
        .zclr_i  (r_q.zclr),
        .cmp_i   (r_q.cmp),
        .cnt_o   (cnt),
        .match_o (match)
    );

    always_comb begin
        wr      = bus_en && bus_we;
        wr_ctrl = wr && (bus_addr == ADDR_CTRL);
        wr_stat = wr && (bus_addr == ADDR_STAT);

        // stopping clears the count only once the reset option has been armed by running
        stop_clr = wr_ctrl && r_q.run && !bus_wdata[CTRL_RUN_BIT]
                   && bus_wdata[CTRL_CRST_BIT] && (r_q.armed || r_q.crst);

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.run    = bus_wdata[CTRL_RUN_BIT];
            r_d.crst   = bus_wdata[CTRL_CRST_BIT];
            r_d.div_en = bus_wdata[CTRL_DIVE_BIT];
        end
        if (wr_ctrl && !bus_wdata[CTRL_CRST_BIT]) r_d.armed = 1'b0;
        else if (r_q.run && r_q.crst)             r_d.armed = 1'b1;

        if (wr && bus_addr == ADDR_IMODE) begin
            r_d.zclr = bus_wdata[IMODE_ZCLR_BIT];
            r_d.ien  = bus_wdata[IMODE_IEN_BIT];
        end
        if (wr && bus_addr == ADDR_DIV) r_d.ccd = bus_wdata[DIV_W-1:0];
        if (wr && bus_addr == ADDR_CMP) r_d.cmp = bus_wdata[CNT_W-1:0];

        if (match)                        r_d.flag = 1'b1;
        else if (wr_stat && !bus_wdata[0]) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmp <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]  = r_q.run;
                bus_rdata[CTRL_CRST_BIT] = r_q.crst;
                bus_rdata[CTRL_DIVE_BIT] = r_q.div_en;
                bus_rdata[5:4]           = MODE_INTERVAL;
            end
            ADDR_STAT:  bus_rdata[0] = r_q.flag;
            ADDR_CMP:   bus_rdata[CNT_W-1:0] = r_q.cmp;
            ADDR_IMODE: begin
                bus_rdata[IMODE_ZCLR_BIT] = r_q.zclr;
                bus_rdata[IMODE_IEN_BIT]  = r_q.ien;
            end
            ADDR_DIV:   bus_rdata[DIV_W-1:0] = r_q.ccd;
            ADDR_CNT:   bus_rdata[CNT_W-1:0] = cnt;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = r_q.flag && r_q.ien;

    // R2: a stopped timer keeps its count
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.run |=> $stable(cnt));

    // R4: a match with zero-clear enabled leaves a zero count
    p_zero_after_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && r_q.zclr) |=> (cnt == '0));

    // R3: the flag only rises because of a match
    p_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag) |-> $past(match));

    // R7: a clearing write with no match in that cycle drops the flag
    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !bus_wdata[0] && !match) |=> !r_q.flag);

    // R8: an armed stop leaves a zero count
    p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clr |=> (cnt == '0));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int TB_W  = 8;
    localparam int NVEC  = 55;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WAIT = 2'd2, OP_IRQ = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    interval_timer #(.CNT_W(TB_W), .DIV_W(3)) i_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {op, requirement number, address, data or expected value}
    localparam logic [45:0] VECS [0:NVEC-1] = '{
        {OP_RD,   4'd1,  8'h00, 32'h0},        // R1 control
        {OP_RD,   4'd1,  8'h04, 32'h0},        // R1 status
        {OP_RD,   4'd1,  8'h08, 32'hFF},       // R1 compare all ones
        {OP_RD,   4'd1,  8'h10, 32'h0},        // R1 interval mode
        {OP_RD,   4'd1,  8'h20, 32'h0},        // R1 divide
        {OP_RD,   4'd1,  8'hF0, 32'h0},        // R1 counter
        {OP_IRQ,  4'd1,  8'h00, 32'h0},        // R1 irq low
        {OP_WR,   4'd0,  8'h08, 32'h4},
        {OP_WR,   4'd0,  8'h10, 32'h3},
        {OP_WR,   4'd0,  8'h00, 32'h1},        // N0 start, one tick per clock
        {OP_RD,   4'd2,  8'hF0, 32'h0},        // N1 R2
        {OP_RD,   4'd9,  8'hF0, 32'h1},        // N2 R9 live count
        {OP_WAIT, 4'd0,  8'h00, 32'h3},        // N3..N5
        {OP_RD,   4'd3,  8'h04, 32'h1},        // N6 R3 match flag
        {OP_IRQ,  4'd6,  8'h00, 32'h1},        // N7 R6
        {OP_RD,   4'd4,  8'hF0, 32'h2},        // N8 R4 restarted from zero
        {OP_WR,   4'd0,  8'h04, 32'h0},        // N9 clear
        {OP_RD,   4'd7,  8'h04, 32'h0},        // N10 R7
        {OP_RD,   4'd3,  8'h04, 32'h1},        // N11 R3 next period
        {OP_WR,   4'd0,  8'h04, 32'h0},        // N12
        {OP_RD,   4'd7,  8'h04, 32'h0},        // N13
        {OP_RD,   4'd4,  8'hF0, 32'h3},        // N14
        {OP_WR,   4'd0,  8'h04, 32'h0},        // N15 clear meets match
        {OP_RD,   4'd7,  8'h04, 32'h1},        // N16 R7 match wins
        {OP_WR,   4'd0,  8'h10, 32'h1},        // N17 interrupt disabled
        {OP_IRQ,  4'd6,  8'h00, 32'h0},        // N18 R6 masked
        {OP_WR,   4'd0,  8'h00, 32'h0},        // N19 stop, no reset option
        {OP_RD,   4'd8,  8'hF0, 32'h4},        // N20 R8 frozen
        {OP_WAIT, 4'd0,  8'h00, 32'h3},
        {OP_RD,   4'd2,  8'hF0, 32'h4},        // N24 R2 held
        {OP_WR,   4'd0,  8'h00, 32'h2},        // N25
        {OP_WR,   4'd0,  8'h00, 32'h3},        // N26 run with reset option
        {OP_RD,   4'd8,  8'h00, 32'h3},        // N27
        {OP_RD,   4'd4,  8'hF0, 32'h0},        // N28
        {OP_WR,   4'd0,  8'h00, 32'h2},        // N29 armed stop
        {OP_RD,   4'd8,  8'hF0, 32'h0},        // N30 R8 cleared
        {OP_WR,   4'd0,  8'h00, 32'h0},        // N31 disarm
        {OP_WR,   4'd0,  8'h00, 32'h1},        // N32 start
        {OP_RD,   4'd2,  8'hF0, 32'h0},        // N33
        {OP_RD,   4'd2,  8'hF0, 32'h1},        // N34
        {OP_WR,   4'd0,  8'h00, 32'h2},        // N35 stop, option not armed
        {OP_RD,   4'd8,  8'hF0, 32'h3},        // N36 R8 freeze
        {OP_WR,   4'd0,  8'h00, 32'h31},       // N37 mode bits written
        {OP_RD,   4'd10, 8'h00, 32'h1},        // N38 R10
        {OP_WR,   4'd0,  8'hF0, 32'h55},       // N39 counter write
        {OP_RD,   4'd9,  8'hF0, 32'h0},        // N40 R9 ignored
        {OP_RD,   4'd9,  8'hF0, 32'h1},        // N41
        {OP_WR,   4'd0,  8'h20, 32'h5},
        {OP_RD,   4'd2,  8'h20, 32'h5},        // R2 divide readback
        {OP_WR,   4'd0,  8'h00, 32'h0},
        {OP_WR,   4'd0,  8'h04, 32'h0},
        {OP_RD,   4'd7,  8'h04, 32'h0},
        {OP_WR,   4'd0,  8'h04, 32'h1},
        {OP_RD,   4'd7,  8'h04, 32'h0},        // R7 writing one keeps it clear
        {OP_IRQ,  4'd6,  8'h00, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [7:0]  a;
            logic [31:0] d;
            {op, rq, a, d} = VECS[i];
            @(negedge clk);
            bus_en = 1'b0; bus_we = 1'b0;
            case (op)
                OP_WR: begin
                    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
                end
                OP_RD: begin
                    bus_addr = a;
                    #1 chk($sformatf("R%0d vector %0d", rq, i), bus_rdata, d);
                end
                OP_WAIT: repeat (d - 1) @(negedge clk);
                default: #1 chk($sformatf("R%0d vector %0d irq", rq, i), {31'h0, irq}, d);
            endcase
        end
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;

        // R1: reset in the middle of a run
        wr(8'h00, 32'h1);
        wr(8'h08, 32'h7);
        do_reset();
        rd("R1 counter after reset", 8'hF0, 32'h0);
        rd("R1 compare after reset", 8'h08, 32'hFF);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2: divide by 4 (ccd = 1), first advance a full period after start
        wr(8'h20, 32'h1);
        wr(8'h00, 32'h5);               // returns at N1
        repeat (3) @(negedge clk);      // N4
        rd("R2 prescaled count N4", 8'hF0, 32'h0);
        @(negedge clk);                 // N5
        rd("R2 prescaled count N5", 8'hF0, 32'h1);
        repeat (4) @(negedge clk);      // N9
        rd("R2 prescaled count N9", 8'hF0, 32'h2);

        // R5: no zero-clear, count past compare and wrap at full width
        do_reset();
        wr(8'h08, 32'h3);
        wr(8'h00, 32'h1);               // returns at N1
        repeat (4) @(negedge clk);      // N5
        rd("R5 count past compare", 8'hF0, 32'h4);
        rd("R3 flag on pass", 8'h04, 32'h1);
        repeat (252) @(negedge clk);    // N257
        rd("R5 wrapped to zero", 8'hF0, 32'h0);
        @(negedge clk);
        rd("R5 after wrap", 8'hF0, 32'h1);

        finish_run();
    end
endmodule